// File: doc/BRIEF.md
# Buffered Dual-Compare PWM Timer

This block is a 16-bit up-counting timer that produces a complementary pair of PWM outputs and two compare interrupt requests. Two compare values set the waveform. Compare B sets the period: the counter returns to zero on the count clock after it matches B. Compare A sets the duty: a match on A drives the output active.

The count clock is one of two sources. It can be the system clock divided by a power of two. It can also be a synchronized external input, so the block works as an event counter.

Software has a small write and read port. Through it, software loads or reads the counter, clears the counter and writes the compare values. When buffering is enabled, compare writes are held in shadow registers. They move into the active registers only at a period boundary or on a software clear, so a new duty or period never produces a partial cycle.

Top module: `pwm_timer`

## Requirements
- R1: Write address 0 loads the counter, and read address 0 returns it. A `cnt_clr` pulse sets the counter to 0 on the next clock and takes priority over a counter write in the same cycle. Read addresses 1 and 2 return the active compare values A and B. Read address 3 returns 0, and write address 3 is ignored.
- R2: The counter advances only on a count tick while `run` is 1. While `run` is 0, the counter holds its value.
- R3: With `ext_sel` at 0, `div_sel` codes 0 to 14 give one count tick every 2^code clock cycles, from a divider that runs freely from reset. Code 15 behaves as code 0.
- R4: With `ext_sel` at 1, each rising edge of `ext_in` passes through a two-flop synchronizer and gives exactly one count tick. The counter changes on the third clock edge after the rising edge.
- R5: On a count tick with the counter equal to active B, the counter becomes 0, which makes the period B+1 ticks.
- R6: On a count tick, a match with A sets the output level to 1 and a match with B clears it to 0, with B winning when both match. `cnt_clr` loads the level from `init_level`. Hardware reset clears the level to 0.
- R7: `pwm_out` equals `out_en & (level ^ invert)`, and `pwm_out_n` is its complement. Both outputs are 0 when `out_en` is 0.
- R8: `irq_a` and `irq_b` each pulse high in the cycle after a count tick that matches A or B, gated by `irq_a_en` and `irq_b_en`.
- R9: With `buf_en` at 0, writes to address 1 (A) or 2 (B) update the active compare register at the next clock.
- R10: With `buf_en` at 1, writes to addresses 1 and 2 leave the active registers unchanged. Both buffers are copied into the active registers on a B match tick or on `cnt_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counting enable |
| ext_sel | input | 1 | 1 selects the external count input |
| div_sel | input | 4 | Divider exponent code |
| ext_in | input | 1 | External count input, asynchronous |
| buf_en | input | 1 | Route compare writes through the shadow buffers |
| out_en | input | 1 | Output enable for both PWM pins |
| init_level | input | 1 | Level loaded on software clear |
| invert | input | 1 | Output polarity flip |
| irq_a_en | input | 1 | Compare A interrupt enable |
| irq_b_en | input | 1 | Compare B interrupt enable |
| cnt_clr | input | 1 | Software counter clear pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 counter, 1 A, 2 B |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data, combinational |
| pwm_out | output | 1 | PWM output |
| pwm_out_n | output | 1 | Complementary PWM output |
| irq_a | output | 1 | Compare A interrupt pulse |
| irq_b | output | 1 | Compare B interrupt pulse |

## Verification
The hardest case to reach is a buffered compare write that lands while the counter runs. The test must show that the active value stays unchanged until the next B match, and then switches exactly at the wrap. The stimulus writes new A and B values in the middle of a period with buffering on, and reads the active registers back on every cycle through a rotating read address. It also drives a write together with a software clear in the same cycle, which shows that the old buffer contents are the values loaded. The slowest divider code is covered by running long enough for two ticks at divide-by-16384.

// File: rtl/pwm_timer.sv
module pwm_timer #(
  parameter int W    = 16,
  parameter int DIVW = 14,
  parameter int SELW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ext_sel,
  input  logic [SELW-1:0] div_sel,
  input  logic          ext_in,
  input  logic          buf_en,
  input  logic          out_en,
  input  logic          init_level,
  input  logic          invert,
  input  logic          irq_a_en,
  input  logic          irq_b_en,
  input  logic          cnt_clr,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [1:0]    rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          pwm_out,
  output logic          pwm_out_n,
  output logic          irq_a,
  output logic          irq_b
);
  localparam logic [SELW-1:0] MAX_CODE = SELW'(DIVW);

  logic [DIVW-1:0] div_cnt;
  logic [2:0]      ext_sync;
  logic [W-1:0]    cnt, cmp_a, cmp_b, buf_a, buf_b;
  logic            level;

  logic [SELW-1:0] shamt;
  logic [DIVW-1:0] mask;
  logic            div_tick, ext_tick, tick, step, hit_a, hit_b;
  logic            wr_cnt, wr_a, wr_b, reload;

  assign shamt    = (div_sel > MAX_CODE) ? '0 : div_sel;
  assign mask     = ~({DIVW{1'b1}} << shamt);
  assign div_tick = &(div_cnt | ~mask);
  assign ext_tick = ext_sync[1] & ~ext_sync[2];
  assign tick     = ext_sel ? ext_tick : div_tick;
  assign step     = run & tick;
  assign hit_a    = step & (cnt == cmp_a);
  assign hit_b    = step & (cnt == cmp_b);
  assign wr_cnt   = wr_en & (wr_addr == 2'd0);
  assign wr_a     = wr_en & (wr_addr == 2'd1);
  assign wr_b     = wr_en & (wr_addr == 2'd2);
  assign reload   = buf_en & (cnt_clr | hit_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      ext_sync <= '0;
    end else begin
      div_cnt  <= div_cnt + 1'b1;
      ext_sync <= {ext_sync[1:0], ext_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (cnt_clr) cnt <= '0;
    else if (wr_cnt)  cnt <= wr_data;
    else if (step)    cnt <= hit_b ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_a <= '0;
      cmp_b <= '0;
      buf_a <= '0;
      buf_b <= '0;
    end else begin
      if (wr_a) buf_a <= wr_data;
      if (wr_b) buf_b <= wr_data;
      if (wr_a && !buf_en) cmp_a <= wr_data;
      else if (reload)     cmp_a <= buf_a;
      if (wr_b && !buf_en) cmp_b <= wr_data;
      else if (reload)     cmp_b <= buf_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b0;
      irq_a <= 1'b0;
      irq_b <= 1'b0;
    end else begin
      if (cnt_clr)    level <= init_level;
      else if (hit_b) level <= 1'b0;
      else if (hit_a) level <= 1'b1;
      irq_a <= hit_a & irq_a_en;
      irq_b <= hit_b & irq_b_en;
    end
  end

  assign pwm_out   = out_en & (level ^ invert);
  assign pwm_out_n = out_en & ~(level ^ invert);

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = cnt;
      2'd1:    rd_data = cmp_a;
      2'd2:    rd_data = cmp_b;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pwm_timer_sva.sv
module pwm_timer_sva #(parameter int W = 16) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         tick,
  input logic         cnt_clr,
  input logic         wr_cnt,
  input logic         buf_en,
  input logic         out_en,
  input logic         irq_a_en,
  input logic         irq_a,
  input logic         pwm_out,
  input logic         pwm_out_n,
  input logic [W-1:0] cnt,
  input logic [W-1:0] cmp_a,
  input logic [W-1:0] cmp_b
);
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> cnt == '0); // R1
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_clr && !wr_cnt) |=> $stable(cnt)); // R2
  AST_B_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && cnt == cmp_b && !cnt_clr && !wr_cnt) |=> cnt == '0); // R5
  AST_OUT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> (pwm_out != pwm_out_n)); // R7
  AST_OUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (!pwm_out && !pwm_out_n)); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a |-> $past(irq_a_en)); // R8
  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && !cnt_clr && !(run && tick)) |=> $stable(cmp_a) && $stable(cmp_b)); // R10
endmodule

bind pwm_timer pwm_timer_sva #(.W(W)) u_sva (
  .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .cnt_clr(cnt_clr),
  .wr_cnt(wr_cnt), .buf_en(buf_en), .out_en(out_en), .irq_a_en(irq_a_en),
  .irq_a(irq_a), .pwm_out(pwm_out), .pwm_out_n(pwm_out_n),
  .cnt(cnt), .cmp_a(cmp_a), .cmp_b(cmp_b)
);

// File: tb/pwm_timer_bench.sv
`timescale 1ns/1ps
module pwm_timer_bench;
  logic clk = 0, rst_n = 0;
  logic run = 0, ext_sel = 0, ext_in = 0, buf_en = 0, out_en = 0;
  logic init_level = 0, invert = 0, irq_a_en = 0, irq_b_en = 0, cnt_clr = 0, wr_en = 0;
  logic [3:0] div_sel = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic pwm_out, pwm_out_n, irq_a, irq_b;

  int checks = 0, failures = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  pwm_timer u_pwm_timer (.*);

  int mc = 0, mca = 0, mcb = 0, mba = 0, mbb = 0, mdiv = 0;
  bit mlvl = 0, mia = 0, mib = 0, ms1 = 0, ms2 = 0, ms3 = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mc = 0; mca = 0; mcb = 0; mba = 0; mbb = 0; mdiv = 0;
      mlvl = 0; mia = 0; mib = 0; ms1 = 0; ms2 = 0; ms3 = 0;
    end else begin
      int n, p, nc, nca, ncb;
      bit t, ha, hb, nl;
      n = (div_sel > 14) ? 0 : int'(div_sel);
      p = 1 << n;
      t = ext_sel ? (ms2 && !ms3) : ((mdiv % p) == p - 1);
      ha = run && t && mc == mca;
      hb = run && t && mc == mcb;
      nc = mc;
      if (cnt_clr) nc = 0;
      else if (wr_en && wr_addr == 0) nc = wr_data;
      else if (run && t) nc = hb ? 0 : (mc + 1) % 65536;
      nca = mca; ncb = mcb;
      if (wr_en && wr_addr == 1 && !buf_en) nca = wr_data;
      else if (buf_en && (cnt_clr || hb)) nca = mba;
      if (wr_en && wr_addr == 2 && !buf_en) ncb = wr_data;
      else if (buf_en && (cnt_clr || hb)) ncb = mbb;
      if (wr_en && wr_addr == 1) mba = wr_data;
      if (wr_en && wr_addr == 2) mbb = wr_data;
      nl = mlvl;
      if (cnt_clr) nl = init_level;
      else if (hb) nl = 0;
      else if (ha) nl = 1;
      mia = ha && irq_a_en;
      mib = hb && irq_b_en;
      mc = nc; mca = nca; mcb = ncb; mlvl = nl;
      mdiv = (mdiv + 1) % 16384;
      ms3 = ms2; ms2 = ms1; ms1 = ext_in;
    end
  end

  task automatic chk(string sig, int act, int exp);
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", cur_req, sig, act, exp, $time);
    end
  endtask

  task automatic compare();
    int erd;
    bit ep;
    checks++;
    case (rd_addr)
      0: erd = mc; 1: erd = mca; 2: erd = mcb; default: erd = 0;
    endcase
    ep = out_en && (mlvl ^ invert);
    chk("rd_data", rd_data, erd);
    chk("pwm_out", pwm_out, ep);
    chk("pwm_out_n", pwm_out_n, out_en && !ep);
    chk("irq_a", irq_a, mia);
    chk("irq_b", irq_b, mib);
  endtask

  task automatic cyc(int n);
    repeat (n) begin
      @(negedge clk);
      compare();
      rd_addr = rd_addr + 1;
    end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = 2'(a); wr_data = 16'(d);
    cyc(1);
    wr_en = 0;
  endtask

  task automatic clr();
    cnt_clr = 1; cyc(1); cnt_clr = 0;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cur_req = "R1"; cyc(3); rst_n = 1; cyc(2);
    wr(0, 16'h1234); cyc(4);
    wr(3, 16'h5555); cyc(4);
    wr_addr = 0; wr_data = 16'h00AA; wr_en = 1; cnt_clr = 1; cyc(1);
    wr_en = 0; cnt_clr = 0; cyc(4);
    cur_req = "R9"; wr(1, 3); wr(2, 9); cyc(4);
    cur_req = "R5"; out_en = 1; irq_a_en = 1; irq_b_en = 1; run = 1; cyc(40);
    cur_req = "R2"; run = 0; cyc(8); run = 1;
    cur_req = "R8"; irq_a_en = 0; cyc(24); irq_a_en = 1; irq_b_en = 0; cyc(12); irq_b_en = 1;
    cur_req = "R3"; div_sel = 2; cyc(60); div_sel = 15; cyc(30); div_sel = 5; cyc(400);
    div_sel = 14; cyc(33000); div_sel = 0;
    cur_req = "R6"; init_level = 1; clr(); cyc(3); init_level = 0; clr(); cyc(12);
    wr(1, 9); cyc(30); wr(1, 3);
    cur_req = "R7"; invert = 1; cyc(20); out_en = 0; cyc(12); out_en = 1; invert = 0; cyc(4);
    cur_req = "R10"; buf_en = 1; wr(1, 5); wr(2, 20); cyc(60);
    wr(1, 2); wr(2, 6); cyc(2);
    wr_addr = 1; wr_data = 7; wr_en = 1; cnt_clr = 1; cyc(1); wr_en = 0; cnt_clr = 0; cyc(30);
    clr(); cyc(20); buf_en = 0;
    cur_req = "R4"; ext_sel = 1;
    for (int i = 0; i < 14; i++) begin ext_in = 1; cyc(3 + i % 3); ext_in = 0; cyc(4); end
    run = 0; ext_in = 1; cyc(5); ext_in = 0; cyc(5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule